// File: doc/BRIEF.md
# FIFO Ready Flag Generator

This block drives the two active-low ready indications that one serial channel gives a DMA engine or a polling host. The receive indication tells the host that enough data is waiting to be read. It goes low when the receive FIFO occupancy reaches a programmable trigger level, or when a receive timeout pulse arrives. It returns high only when the FIFO drains to empty or when the FIFO reports an error. The transmit indication tells the host that the transmit FIFO can take a burst. It goes low when the number of free entries is at least a programmable trigger level. It returns high only when the FIFO is full.

Because each flag is set and cleared by different conditions, it behaves as a set/reset flag with hysteresis and not as a plain comparator. When neither condition holds, the flag keeps its last value. When both hold in the same cycle, the clearing condition wins. Both outputs are registered, so they respond one clock after the inputs change. The FIFOs, the timeout counter and the trigger-level register decode sit outside this block. The default FIFO depth is 64 entries.

Top module: `fifo_ready_flags`

## Requirements
- R1: While reset is asserted, and on the first clock after it, both `rx_rdy_n` and `tx_rdy_n` are 1 (inactive).
- R2: If `rx_level >= rx_trig`, `rx_level != 0` and `rx_fault` is 0, then `rx_rdy_n` is 0 after the next rising clock edge. This includes the boundary `rx_trig = rx_level = 64`.
- R3: A one-cycle `rx_tmo` pulse with `rx_level` nonzero and below `rx_trig`, and `rx_fault` at 0, drives `rx_rdy_n` to 0 after the next clock edge.
- R4: If `rx_level == 0`, `rx_rdy_n` is 1 after the next clock edge. This holds even when `rx_tmo` is high or `rx_trig` is 0.
- R5: If `rx_fault` is 1, `rx_rdy_n` is 1 after the next clock edge. This holds even when the level has reached the trigger or `rx_tmo` is high.
- R6: When no receive set condition (R2, R3) and no receive clear condition (R4, R5) holds, `rx_rdy_n` keeps its previous value.
- R7: If the free space `64 - tx_level` is at least `tx_trig` and `tx_level != 64`, then `tx_rdy_n` is 0 after the next clock edge.
- R8: If `tx_level == 64`, `tx_rdy_n` is 1 after the next clock edge, even when `tx_trig` is 0.
- R9: When the free space is below `tx_trig` and the FIFO is not full, `tx_rdy_n` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_level | input | 7 | Receive FIFO occupancy, 0 to 64 |
| rx_trig | input | 7 | Receive trigger level |
| rx_tmo | input | 1 | Receive timeout pulse, one cycle |
| rx_fault | input | 1 | Receive FIFO holds an error |
| tx_level | input | 7 | Transmit FIFO occupancy, 0 to 64 |
| tx_trig | input | 7 | Transmit trigger level, in free entries |
| rx_rdy_n | output | 1 | Receive ready, active low |
| tx_rdy_n | output | 1 | Transmit ready, active low |

## Verification
The bench checks that the hysteresis band really holds a flag, for both the low and the high state. A design built as a comparator would release `rx_rdy_n` as soon as the level dropped below the trigger. The bench applies set and clear conditions together: a timeout while the FIFO is empty, a full FIFO with a zero trigger, and an error at a level above the trigger. A design with the wrong priority would show the flag low in those cases. It also checks the exact boundaries: a level equal to the trigger, free space equal to the trigger, and a level of 63 against a level of 64. An off-by-one compare would miss the edge there.

// File: rtl/rdy_flag_pkg.sv
package rdy_flag_pkg;
    localparam int unsigned FIFO_DEPTH = 64;
    localparam int unsigned LVL_W      = $clog2(FIFO_DEPTH + 1);

    typedef enum logic [0:0] {
        LANE_RX = 1'b0,
        LANE_TX = 1'b1
    } lane_e;

    localparam int unsigned NUM_LANES = 2;

    typedef struct packed {
        logic rdy_n;
    } flag_state_t;
endpackage

// File: rtl/rx_ready_cond.sv
module rx_ready_cond #(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
    input  logic [LW-1:0] level_i,
    input  logic [LW-1:0] trig_i,
    input  logic          tmo_i,
    input  logic          fault_i,
    output logic          set_o,
    output logic          clr_o
);
    logic empty;
    logic reached;

    always_comb begin
        empty   = (level_i == '0);
        reached = (level_i >= trig_i);
        clr_o   = empty | fault_i;
        set_o   = reached | tmo_i;
    end
endmodule

// File: rtl/tx_ready_cond.sv
module tx_ready_cond #(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
    input  logic [LW-1:0] level_i,
    input  logic [LW-1:0] trig_i,
    output logic          set_o,
    output logic          clr_o
);
    localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

    logic [LW-1:0] space;

    always_comb begin
        space = FULL_LVL - level_i;
        clr_o = (level_i == FULL_LVL);
        set_o = (space >= trig_i);
    end
endmodule

// File: rtl/ready_latch.sv
module ready_latch
    import rdy_flag_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic rdy_n_o
);
    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.rdy_n = 1'b1;
        end else if (set_i) begin
            st_d.rdy_n = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{rdy_n: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign rdy_n_o = st_q.rdy_n;

    // clear has priority over set (R4, R5, R8)
    p_clear_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (clr_i && set_i) |=> rdy_n_o);
    // no condition holds the flag (R6, R9)
    p_idle_holds_r9: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !set_i) |=> $stable(rdy_n_o));
endmodule

// File: rtl/fifo_ready_flags.sv
module fifo_ready_flags
    import rdy_flag_pkg::*;
#(
    parameter int unsigned DEPTH = FIFO_DEPTH,
    localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [LW-1:0] rx_level,
    input  logic [LW-1:0] rx_trig,
    input  logic          rx_tmo,
    input  logic          rx_fault,
    input  logic [LW-1:0] tx_level,
    input  logic [LW-1:0] tx_trig,
    output logic          rx_rdy_n,
    output logic          tx_rdy_n
);
    logic [NUM_LANES-1:0] lane_set;
    logic [NUM_LANES-1:0] lane_clr;
    logic [NUM_LANES-1:0] lane_rdy_n;

    rx_ready_cond #(.DEPTH(DEPTH)) u_rx_cond (
        .level_i (rx_level),
        .trig_i  (rx_trig),
        .tmo_i   (rx_tmo),
        .fault_i (rx_fault),
        .set_o   (lane_set[LANE_RX]),
        .clr_o   (lane_clr[LANE_RX])
    );

    tx_ready_cond #(.DEPTH(DEPTH)) u_tx_cond (
        .level_i (tx_level),
        .trig_i  (tx_trig),
        .set_o   (lane_set[LANE_TX]),
        .clr_o   (lane_clr[LANE_TX])
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        ready_latch u_flag (
            .clk     (clk),
            .rst     (rst),
            .set_i   (lane_set[g]),
            .clr_i   (lane_clr[g]),
            .rdy_n_o (lane_rdy_n[g])
        );
    end

    assign rx_rdy_n = lane_rdy_n[LANE_RX];
    assign tx_rdy_n = lane_rdy_n[LANE_TX];

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (rx_rdy_n && tx_rdy_n));
    p_rx_reach_r2: assert property (@(posedge clk) disable iff (rst)
        (rx_level >= rx_trig && rx_level != '0 && !rx_fault) |=> !rx_rdy_n);
    p_rx_timeout_r3: assert property (@(posedge clk) disable iff (rst)
        (rx_tmo && rx_level != '0 && !rx_fault) |=> !rx_rdy_n);
    p_rx_empty_r4: assert property (@(posedge clk) disable iff (rst)
        (rx_level == '0) |=> rx_rdy_n);
    p_rx_fault_r5: assert property (@(posedge clk) disable iff (rst)
        rx_fault |=> rx_rdy_n);
    p_rx_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (rx_level != '0 && !rx_fault && !rx_tmo && rx_level < rx_trig)
        |=> $stable(rx_rdy_n));
    p_tx_space_r7: assert property (@(posedge clk) disable iff (rst)
        (tx_level != LW'(DEPTH) && (LW'(DEPTH) - tx_level) >= tx_trig) |=> !tx_rdy_n);
    p_tx_full_r8: assert property (@(posedge clk) disable iff (rst)
        (tx_level == LW'(DEPTH)) |=> tx_rdy_n);
endmodule

// File: tb/tb_fifo_ready_flags.sv
module tb_fifo_ready_flags;
    localparam int DEPTH = 64;
    localparam int LW    = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [LW-1:0] rx_level = '0, rx_trig = '0, tx_level = '0, tx_trig = '0;
    logic          rx_tmo = 1'b0, rx_fault = 1'b0;
    logic          rx_rdy_n, tx_rdy_n;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    typedef struct {
        logic  rx;
        logic  tx;
        string tag;
    } exp_t;
    exp_t sb[$];

    logic m_rx = 1'b1, m_tx = 1'b1;

    always #5 clk = ~clk;

    fifo_ready_flags dut (
        .clk(clk), .rst(rst),
        .rx_level(rx_level), .rx_trig(rx_trig), .rx_tmo(rx_tmo), .rx_fault(rx_fault),
        .tx_level(tx_level), .tx_trig(tx_trig),
        .rx_rdy_n(rx_rdy_n), .tx_rdy_n(tx_rdy_n)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // driver: apply one cycle of stimulus, predict the flags from the requirements
    task automatic step(input int rl, input int rt, input bit tmo, input bit flt,
                        input int tl, input int tt, input string tag);
        exp_t e;
        @(negedge clk);
        rx_level = LW'(rl); rx_trig = LW'(rt); rx_tmo = tmo; rx_fault = flt;
        tx_level = LW'(tl); tx_trig = LW'(tt);
        if (rl == 0 || flt)            m_rx = 1'b1;
        else if (rl >= rt || tmo)      m_rx = 1'b0;
        if (tl == DEPTH)               m_tx = 1'b1;
        else if ((DEPTH - tl) >= tt)   m_tx = 1'b0;
        e.rx = m_rx; e.tx = m_tx; e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: after each edge, compare against the oldest prediction
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " rx_rdy_n"}, rx_rdy_n, e.rx);
                check({e.tag, " tx_rdy_n"}, tx_rdy_n, e.tx);
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rx_trig = 7'd8; tx_trig = 7'd16; tx_level = 7'd50; rx_level = 7'd3;
        repeat (3) @(negedge clk);
        check("R1 reset rx", rx_rdy_n, 1'b1);
        check("R1 reset tx", tx_rdy_n, 1'b1);
        rst = 1'b0;
        // first cycle after reset: rx below trig, tx space below trig -> both hold high
        step(3, 8, 0, 0, 50, 16, "R1/R6/R9 after reset");
        step(8, 8, 0, 0, 48, 16, "R2/R7 at threshold");
        step(5, 8, 0, 0, 60, 16, "R6/R9 hold low");
        step(0, 8, 0, 0, 64, 16, "R4/R8 empty and full");
        step(2, 8, 1, 0, 55, 16, "R3 timeout, R9 hold high");
        step(2, 8, 0, 0, 55, 16, "R6 hold after timeout");
        step(2, 8, 0, 1, 48, 16, "R5 fault below trig, R7");
        step(10, 8, 0, 1, 48, 16, "R5 fault above trig");
        step(10, 8, 0, 0, 63, 1, "R2 after fault, R7 one free");
        step(0, 8, 1, 0, 64, 0, "R4 empty beats timeout, R8 full with trig 0");
        step(0, 0, 0, 0, 63, 0, "R4 empty with trig 0, R7 trig 0");
        step(64, 64, 0, 0, 0, 64, "R2 full level trig 64, R7 empty tx trig 64");
        step(30, 64, 0, 0, 10, 64, "R6/R9 hold low in band");
        step(30, 64, 1, 1, 64, 64, "R5 fault beats timeout, R8");
        step(30, 64, 0, 0, 1, 64, "R6/R9 hold high in band");
        step(1, 1, 0, 0, 0, 64, "R2 level one trig one, R7");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule